// File: doc/BRIEF.md
# Shared-Bus Register Bank Controller

This block holds a bank of equally wide registers that all sit on one internal data bus. A binary address picks one register. A shared read strobe and a shared write strobe are combined with that one selection, so in any cycle at most one register places its contents on the bus and at most one register captures a value. Because on-chip tristate lines are not used, the bus is modelled as a select-and-combine network. Its registered output carries a valid flag. When nothing drives the bus, the flag is low and the data is zero.

Two kinds of traffic use the bank. The first is direct access from the surrounding logic: a single-cycle read or a single-cycle write. The second is a register-to-register move that a small sequencer runs in two phases. In the first phase the source register drives the bus. In the second phase the destination register latches the bus value. A busy flag covers both phases, and a one-cycle done pulse marks the completed write. Requesting a read and a write in the same cycle is an illegal request: it is refused and flagged.

Top module: `regbus_bank`

## Requirements
- R1: A synchronous active-high reset clears every register to zero, returns the sequencer to idle and drives bus_valid, acc_reject, mv_busy and mv_done low.
- R2: A direct read (acc_rd=1, acc_wr=0) of address a, made while the sequencer is idle and mv_req is low, shows register a on bus_data with bus_valid=1 after the next clock edge.
- R3: A direct write (acc_wr=1, acc_rd=0) of address a stores acc_wdata into register a at that clock edge. No other register changes.
- R4: After any cycle in which no register is read, bus_valid is 0 and bus_data is all zeros (the floating bus).
- R5: A cycle with both acc_rd=1 and acc_wr=1, while the sequencer is idle and mv_req is low, changes no register, leaves bus_valid low and raises acc_reject for exactly the following cycle.
- R6: In every cycle at most one register is read-enabled and at most one is write-enabled, and no read and write are enabled together.
- R7: A move request accepted while idle raises mv_busy after its edge. mv_busy stays high for exactly two cycles. Then mv_busy falls and mv_done is high for exactly one cycle.
- R8: During a move, the cycle after mv_busy rises shows the source register on bus_data with bus_valid=1. When mv_done rises, the destination register holds that value.
- R9: A move whose source equals its destination completes with the normal timing and leaves the register unchanged.
- R10: While mv_busy is high, direct reads, direct writes and new move requests are ignored. In an idle cycle with mv_req high, mv_req takes priority: any direct access in that cycle is ignored and raises no acc_reject.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_addr | input | ADDR_W | Direct-access register address |
| acc_rd | input | 1 | Direct read strobe |
| acc_wr | input | 1 | Direct write strobe |
| acc_wdata | input | DATA_W | Direct write data |
| mv_req | input | 1 | Move request |
| mv_src | input | ADDR_W | Move source address |
| mv_dst | input | ADDR_W | Move destination address |
| bus_data | output | DATA_W | Registered bus value |
| bus_valid | output | 1 | High when a register drove the bus in the previous cycle |
| acc_reject | output | 1 | Pulse for a refused read-and-write request |
| mv_busy | output | 1 | Move in progress |
| mv_done | output | 1 | One-cycle pulse at move completion |

## Verification
The hardest situation to reach is a conflict between the move sequencer and the direct port. Two cases matter. In the first, direct traffic and a fresh move request arrive while a move sits between its read and write phases. In the second, a move request arrives in the same idle cycle as a read-and-write conflict. The stimulus creates both on purpose. It fires a write to the move's own destination and a second move request during the read phase. It raises mv_req together with both direct strobes. It then reads the affected registers back over the bus to show that nothing leaked through.

// File: rtl/regbus_pkg.sv
package regbus_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_READ  = 2'd1,
    SEQ_WRITE = 2'd2
  } seq_state_t;
endpackage

// File: rtl/regbus_addr_decoder.sv
module regbus_addr_decoder #(
  parameter int NUM_REGS = 8,
  localparam int ADDR_W = $clog2(NUM_REGS)
) (
  input  logic [ADDR_W-1:0]   addr,
  output logic [NUM_REGS-1:0] sel
);
  // one comparator per register yields a one-hot select
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_dec
    assign sel[i] = (addr == ADDR_W'(i));
  end
endmodule

// File: rtl/regbus_strobe_gate.sv
module regbus_strobe_gate #(
  parameter int NUM_REGS = 8
) (
  input  logic [NUM_REGS-1:0] sel,
  input  logic                rd,
  input  logic                wr,
  output logic [NUM_REGS-1:0] rd_en,
  output logic [NUM_REGS-1:0] wr_en
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_gate
    assign rd_en[i] = rd & sel[i];
    assign wr_en[i] = wr & sel[i];
  end
endmodule

// File: rtl/regbus_storage.sv
module regbus_storage #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 8
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [NUM_REGS-1:0]              wr_en,
  input  logic [DATA_W-1:0]                wdata,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  q
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)           q[i] <= '0;
      else if (wr_en[i]) q[i] <= wdata;
    end
  end
endmodule

// File: rtl/regbus_bus_mux.sv
module regbus_bus_mux #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 8
) (
  input  logic [NUM_REGS-1:0]             rd_en,
  input  logic [NUM_REGS-1:0][DATA_W-1:0] q,
  output logic [DATA_W-1:0]               bus_next,
  output logic                            bus_any
);
  // AND-OR network standing in for the tristate bus: a floating bus reads zero
  always_comb begin
    bus_next = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_en[i]) bus_next = bus_next | q[i];
    end
    bus_any = |rd_en;
  end
endmodule

// File: rtl/regbus_move_seq.sv
module regbus_move_seq
  import regbus_pkg::*;
#(
  parameter int NUM_REGS = 8,
  localparam int ADDR_W = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic [ADDR_W-1:0] src,
  input  logic [ADDR_W-1:0] dst,
  output seq_state_t        state,
  output logic [ADDR_W-1:0] cur_src,
  output logic [ADDR_W-1:0] cur_dst,
  output logic              busy,
  output logic              done
);
  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SEQ_IDLE;
      cur_src <= '0;
      cur_dst <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        SEQ_IDLE: if (req) begin
          state   <= SEQ_READ;
          cur_src <= src;
          cur_dst <= dst;
          busy    <= 1'b1;
        end
        SEQ_READ: state <= SEQ_WRITE;
        SEQ_WRITE: begin
          state <= SEQ_IDLE;
          busy  <= 1'b0;
          done  <= 1'b1;
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/regbus_bank.sv
module regbus_bank
  import regbus_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 8,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_rd,
  input  logic              acc_wr,
  input  logic [DATA_W-1:0] acc_wdata,
  input  logic              mv_req,
  input  logic [ADDR_W-1:0] mv_src,
  input  logic [ADDR_W-1:0] mv_dst,
  output logic [DATA_W-1:0] bus_data,
  output logic              bus_valid,
  output logic              acc_reject,
  output logic              mv_busy,
  output logic              mv_done
);
  seq_state_t                      seq_state;
  logic [ADDR_W-1:0]               seq_src, seq_dst;
  logic                            direct_ok;
  logic [ADDR_W-1:0]               eff_addr;
  logic                            eff_rd, eff_wr;
  logic [DATA_W-1:0]               eff_wdata;
  logic [NUM_REGS-1:0]             sel, rd_en, wr_en;
  logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;
  logic [DATA_W-1:0]               bus_next;
  logic                            bus_any;

  regbus_move_seq #(.NUM_REGS(NUM_REGS)) seq_i (
    .clk(clk), .rst(rst), .req(mv_req), .src(mv_src), .dst(mv_dst),
    .state(seq_state), .cur_src(seq_src), .cur_dst(seq_dst),
    .busy(mv_busy), .done(mv_done)
  );

  // direct port only when the sequencer neither runs nor starts
  assign direct_ok = (seq_state == SEQ_IDLE) && !mv_req;

  always_comb begin
    eff_addr  = acc_addr;
    eff_rd    = direct_ok && acc_rd && !acc_wr;
    eff_wr    = direct_ok && acc_wr && !acc_rd;
    eff_wdata = acc_wdata;
    if (seq_state == SEQ_READ) begin
      eff_addr = seq_src;
      eff_rd   = 1'b1;
      eff_wr   = 1'b0;
    end else if (seq_state == SEQ_WRITE) begin
      eff_addr  = seq_dst;
      eff_rd    = 1'b0;
      eff_wr    = 1'b1;
      eff_wdata = bus_data;
    end
  end

  regbus_addr_decoder #(.NUM_REGS(NUM_REGS)) dec_i (
    .addr(eff_addr), .sel(sel)
  );

  regbus_strobe_gate #(.NUM_REGS(NUM_REGS)) gate_i (
    .sel(sel), .rd(eff_rd), .wr(eff_wr), .rd_en(rd_en), .wr_en(wr_en)
  );

  regbus_storage #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) store_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wdata(eff_wdata), .q(regs_q)
  );

  regbus_bus_mux #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) mux_i (
    .rd_en(rd_en), .q(regs_q), .bus_next(bus_next), .bus_any(bus_any)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_data   <= '0;
      bus_valid  <= 1'b0;
      acc_reject <= 1'b0;
    end else begin
      bus_data   <= bus_next;
      bus_valid  <= bus_any;
      acc_reject <= direct_ok && acc_rd && acc_wr;
    end
  end
endmodule

// File: rtl/regbus_bank_chk.sv
module regbus_bank_chk #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 8
) (
  input logic                clk,
  input logic                rst,
  input logic [NUM_REGS-1:0] rd_en,
  input logic [NUM_REGS-1:0] wr_en,
  input logic                acc_rd,
  input logic                acc_wr,
  input logic                mv_req,
  input logic                mv_busy,
  input logic                mv_done,
  input logic                bus_valid,
  input logic [DATA_W-1:0]   bus_data,
  input logic                acc_reject
);
  a_r6_single_reader: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rd_en));
  a_r6_single_writer: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_en));
  a_r6_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !((|rd_en) && (|wr_en)));
  a_r2_read_valid: assert property (@(posedge clk) disable iff (rst)
    (|rd_en) |=> bus_valid);
  a_r4_idle_float: assert property (@(posedge clk) disable iff (rst)
    !(|rd_en) |=> (!bus_valid && bus_data == '0));
  a_r5_reject_flag: assert property (@(posedge clk) disable iff (rst)
    (acc_rd && acc_wr && !mv_busy && !mv_req) |=> acc_reject);
  a_r5_reject_no_write: assert property (@(posedge clk) disable iff (rst)
    (acc_rd && acc_wr && !mv_busy && !mv_req) |-> (wr_en == '0));
  a_r7_start: assert property (@(posedge clk) disable iff (rst)
    (mv_req && !mv_busy) |=> mv_busy);
  a_r7_busy_hold: assert property (@(posedge clk) disable iff (rst)
    $rose(mv_busy) |=> mv_busy);
  a_r7_done_after_busy: assert property (@(posedge clk) disable iff (rst)
    mv_done |-> (!mv_busy && $past(mv_busy)));
  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    mv_done |=> !mv_done);
endmodule

bind regbus_bank regbus_bank_chk #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .acc_rd(acc_rd),
  .acc_wr(acc_wr), .mv_req(mv_req), .mv_busy(mv_busy), .mv_done(mv_done),
  .bus_valid(bus_valid), .bus_data(bus_data), .acc_reject(acc_reject)
);

// File: tb/regbus_bank_tb_top.sv
module regbus_bank_tb_top;
  localparam int NR = 8;
  localparam int DW = 8;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] acc_addr = '0;
  logic          acc_rd = 1'b0, acc_wr = 1'b0;
  logic [DW-1:0] acc_wdata = '0;
  logic          mv_req = 1'b0;
  logic [AW-1:0] mv_src = '0, mv_dst = '0;
  logic [DW-1:0] bus_data;
  logic          bus_valid, acc_reject, mv_busy, mv_done;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  regbus_bank #(.NUM_REGS(NR), .DATA_W(DW)) dut_i (
    .clk(clk), .rst(rst), .acc_addr(acc_addr), .acc_rd(acc_rd), .acc_wr(acc_wr),
    .acc_wdata(acc_wdata), .mv_req(mv_req), .mv_src(mv_src), .mv_dst(mv_dst),
    .bus_data(bus_data), .bus_valid(bus_valid), .acc_reject(acc_reject),
    .mv_busy(mv_busy), .mv_done(mv_done)
  );

  // row: {op[1]=read, op[0]=write, addr[2:0], data[7:0], exp_valid, exp_data[7:0]}
  localparam int TBL_N = 12;
  localparam logic [21:0] TBL [TBL_N] = '{
    {2'b01, 3'd0, 8'h11, 1'b0, 8'h00},
    {2'b01, 3'd1, 8'h22, 1'b0, 8'h00},
    {2'b01, 3'd7, 8'hF0, 1'b0, 8'h00},
    {2'b10, 3'd0, 8'h00, 1'b1, 8'h11},
    {2'b10, 3'd7, 8'h00, 1'b1, 8'hF0},
    {2'b10, 3'd1, 8'h00, 1'b1, 8'h22},
    {2'b11, 3'd1, 8'h99, 1'b0, 8'h00},
    {2'b10, 3'd1, 8'h00, 1'b1, 8'h22},
    {2'b00, 3'd2, 8'h44, 1'b0, 8'h00},
    {2'b10, 3'd3, 8'h00, 1'b1, 8'h00},
    {2'b01, 3'd3, 8'h5A, 1'b0, 8'h00},
    {2'b10, 3'd3, 8'h00, 1'b1, 8'h5A}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_in();
    acc_rd = 1'b0; acc_wr = 1'b0; mv_req = 1'b0;
  endtask

  task automatic read_chk(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string req);
    acc_addr = a; acc_rd = 1'b1;
    step();
    idle_in();
    check({req, " read valid"}, 16'(bus_valid), 16'd1);
    check({req, " read data"}, 16'(bus_data), 16'(exp));
  endtask

  task automatic move_chk(input logic [AW-1:0] s, input logic [AW-1:0] d,
                          input logic [DW-1:0] sval, input string req);
    mv_src = s; mv_dst = d; mv_req = 1'b1;
    step();
    idle_in();
    check({req, " busy after accept (R7)"}, 16'(mv_busy), 16'd1);
    check({req, " no early done (R7)"}, 16'(mv_done), 16'd0);
    step();
    check({req, " busy in read phase (R7)"}, 16'(mv_busy), 16'd1);
    check({req, " bus valid in read phase (R8)"}, 16'(bus_valid), 16'd1);
    check({req, " bus shows source (R8)"}, 16'(bus_data), 16'(sval));
    step();
    check({req, " busy falls (R7)"}, 16'(mv_busy), 16'd0);
    check({req, " done pulse (R7)"}, 16'(mv_done), 16'd1);
    step();
    check({req, " done one cycle (R7)"}, 16'(mv_done), 16'd0);
  endtask

  initial begin
    repeat (3) step();
    rst = 1'b0;
    // R1: reset state at the ports
    check("R1 bus_valid", 16'(bus_valid), 16'd0);
    check("R1 bus_data", 16'(bus_data), 16'd0);
    check("R1 busy", 16'(mv_busy), 16'd0);
    check("R1 done", 16'(mv_done), 16'd0);
    check("R1 reject", 16'(acc_reject), 16'd0);
    read_chk(3'd4, 8'h00, "R1 cleared reg");

    // table walk: R2 reads, R3 writes, R4 idle bus, R5 conflicts
    for (int k = 0; k < TBL_N; k++) begin
      logic [1:0] op;
      logic [AW-1:0] a;
      logic [DW-1:0] d, ed;
      logic ev;
      string tag;
      {op, a, d, ev, ed} = TBL[k];
      tag = (op == 2'b10) ? "R2" : (op == 2'b01) ? "R3" : (op == 2'b00) ? "R4" : "R5";
      acc_addr = a; acc_wdata = d; acc_rd = op[1]; acc_wr = op[0];
      step();
      idle_in();
      check($sformatf("%s row %0d valid", tag, k), 16'(bus_valid), 16'(ev));
      check($sformatf("%s row %0d data", tag, k), 16'(bus_data), 16'(ed));
      check($sformatf("%s row %0d reject", tag, k), 16'(acc_reject), 16'(op == 2'b11));
    end
    step();
    check("R5 reject single cycle", 16'(acc_reject), 16'd0);
    check("R4 floating after idle", 16'(bus_valid), 16'd0);

    // R8: plain move
    move_chk(3'd0, 3'd5, 8'h11, "R8 move 0->5");
    read_chk(3'd5, 8'h11, "R8 destination");
    read_chk(3'd0, 8'h11, "R8 source kept");

    // R9: source equals destination
    move_chk(3'd7, 3'd7, 8'hF0, "R9 move 7->7");
    read_chk(3'd7, 8'hF0, "R9 unchanged");

    // R10: traffic during the read phase is ignored
    mv_src = 3'd1; mv_dst = 3'd2; mv_req = 1'b1;
    step();
    mv_src = 3'd3; mv_dst = 3'd6; mv_req = 1'b1;
    acc_addr = 3'd2; acc_wdata = 8'hEE; acc_wr = 1'b1;
    step();
    idle_in();
    check("R10 bus shows source despite traffic", 16'(bus_data), 16'h22);
    check("R10 no reject while busy", 16'(acc_reject), 16'd0);
    step();
    check("R10 done", 16'(mv_done), 16'd1);
    step();
    check("R10 no second move", 16'(mv_busy), 16'd0);
    read_chk(3'd2, 8'h22, "R10 dst holds moved value");
    read_chk(3'd6, 8'h00, "R10 ignored move request");

    // R10: mv_req wins over a same-cycle conflicting direct access
    mv_src = 3'd3; mv_dst = 3'd4; mv_req = 1'b1;
    acc_addr = 3'd6; acc_wdata = 8'h77; acc_rd = 1'b1; acc_wr = 1'b1;
    step();
    idle_in();
    check("R10 no reject under move request", 16'(acc_reject), 16'd0);
    repeat (3) step();
    read_chk(3'd4, 8'h5A, "R10 priority move result");
    read_chk(3'd6, 8'h00, "R10 direct access dropped");

    // R1: reset mid-run
    rst = 1'b1;
    step();
    rst = 1'b0;
    check("R1 re-reset valid", 16'(bus_valid), 16'd0);
    read_chk(3'd5, 8'h00, "R1 re-reset clears reg");
    read_chk(3'd0, 8'h00, "R1 re-reset clears reg0");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule